// File: doc/BRIEF.md
# Serial and parallel configuration loader

This block holds the working configuration of a clock synthesizer: a 3-bit test selector, a 2-bit output-divider code and a 9-bit loop-divider value. A board controller can set the divider fields through a parallel port with its own load strobe. A 3-wire serial port, made of data, shift clock and load strobe, can set all three fields. Both strobes and the serial pins are brought into the system clock through two-stage synchronizers. Each load path then acts as a transparent latch on the synchronized strobe level.

While the parallel strobe is low, the divider fields track the parallel inputs and the test selector is forced to zero. When the parallel strobe rises, those values are held. While the parallel strobe is high and the serial strobe is high, all fields track the serial shift register. When the serial strobe falls, they are held. The parallel path wins whenever both strobes are active. The top bit of the shift register is also presented as an output, so that a test selector can observe it.

Top module: `cfg_loader`

## Requirements
- R1: The 14-bit shift register advances by one bit, taking the synchronized serial data into its bottom position, once per rising edge of the serial clock and at no other time. Without a serial clock rise, `sr_last` does not change.
- R2: After 14 serial bits with the parallel strobe high, a serial load puts the bits into the fields in this order. The first three bits sent are `t_sel[2]`, `t_sel[1]` and `t_sel[0]`. The next two are `n_code[1]` and `n_code[0]`. The last nine are `m_val[8]` down to `m_val[0]`.
- R3: While `pload` is high and `sload` is high, all three fields follow the shift register. Each further serial bit changes them.
- R4: After `sload` falls with `pload` high, all three fields hold their values while more serial bits are shifted in.
- R5: While `pload` is low, `m_val` follows `m_in` and `n_code` follows `n_in`, including changes that occur while the strobe stays low.
- R6: After `pload` rises, `m_val` and `n_code` hold their values when `m_in` and `n_in` change.
- R7: When `pload` is low and `sload` is high at the same time, the fields take the parallel values with `t_sel` = 000. When `pload` then rises while `sload` is still high, the fields switch to the shift-register contents.
- R8: While `pload` is low, `t_sel` reads 000. After `pload` rises, `t_sel` stays 000 until a serial load.
- R9: `sr_last` is the bit that was shifted in 13 serial clock rises before the latest one, which is the first bit of the last 14 sent.
- R10: While `rst_n` is low, the shift register is cleared, so `sr_last` = 0. `t_sel` reads 000, and `m_val` and `n_code` take `m_in` and `n_in`.
- R11: A change on a strobe or serial pin appears at the outputs within 4 system clock cycles. `n_code` values 00, 01, 10 and 11 stand for output division by 2, 4, 8 and 16. The block passes the code through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sdata | input | 1 | Serial data |
| sclk | input | 1 | Serial shift clock; shifts on its rising edge |
| sload | input | 1 | Serial load strobe; transparent when high |
| pload | input | 1 | Parallel load strobe; transparent when low |
| m_in | input | 9 | Parallel loop-divider value |
| n_in | input | 2 | Parallel output-divider code |
| t_sel | output | 3 | Test selector field |
| n_code | output | 2 | Output-divider code field |
| m_val | output | 9 | Loop-divider field |
| sr_last | output | 1 | Top bit of the shift register |

## Verification
Two functions can fall in the same cycle.

The first pair is the two load paths, both transparent at once. To provoke it, the bench holds `sload` high with a nonzero test field sitting in the shift register, and then drops `pload`. The result is judged correct when the parallel values win with a zero test field, and when the serial contents take over as soon as `pload` rises alone.

The second pair is serial shifting while the serial latch is transparent. The bench shifts one extra bit with `sload` still high and expects every field to move to the shifted word. Once `sload` falls, another full word must leave the fields untouched.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int MW   = 9,
  parameter int NW   = 2,
  parameter int TW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdata,
  input  logic          sclk,
  input  logic          sload,
  input  logic          pload,
  input  logic [MW-1:0] m_in,
  input  logic [NW-1:0] n_in,
  output logic [TW-1:0] t_sel,
  output logic [NW-1:0] n_code,
  output logic [MW-1:0] m_val,
  output logic          sr_last
);
  localparam int SRW = TW + NW + MW;

  logic [SYNC-1:0] sclk_p, sdata_p, sload_p, pload_p;
  logic            sclk_d;
  logic [SRW-1:0]  sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= '0;
      sdata_p <= '0;
      sload_p <= '0;
      pload_p <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_p  <= {sclk_p[SYNC-2:0], sclk};
      sdata_p <= {sdata_p[SYNC-2:0], sdata};
      sload_p <= {sload_p[SYNC-2:0], sload};
      pload_p <= {pload_p[SYNC-2:0], pload};
      sclk_d  <= sclk_p[SYNC-1];
    end
  end

  wire sclk_s   = sclk_p[SYNC-1];
  wire sdata_s  = sdata_p[SYNC-1];
  wire sload_s  = sload_p[SYNC-1];
  wire pload_s  = pload_p[SYNC-1];
  wire shift_en = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {sr[SRW-2:0], sdata_s};
  end

  assign sr_last = sr[SRW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_sel  <= '0;
      n_code <= n_in;
      m_val  <= m_in;
    end else if (!pload_s) begin
      t_sel  <= '0;
      n_code <= n_in;
      m_val  <= m_in;
    end else if (sload_s) begin
      {t_sel, n_code, m_val} <= sr;
    end
  end

  // R8
  t_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_s |=> t_sel == '0);

  // R5
  par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_s |=> (m_val == $past(m_in)) && (n_code == $past(n_in)));

  // R4
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_s && !sload_s) |=> $stable({t_sel, n_code, m_val}));

  // R3
  ser_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_s && sload_s) |=> {t_sel, n_code, m_val} == $past(sr));

  // R1
  no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_last));
endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdata = 1'b0, sclk = 1'b0, sload = 1'b0, pload = 1'b1;
  logic [8:0] m_in = 9'd200;
  logic [1:0] n_in = 2'b01;
  logic [2:0] t_sel;
  logic [1:0] n_code;
  logic [8:0] m_val;
  logic       sr_last;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  cfg_loader dut (.clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk),
    .sload(sload), .pload(pload), .m_in(m_in), .n_in(n_in),
    .t_sel(t_sel), .n_code(n_code), .m_val(m_val), .sr_last(sr_last));

  localparam logic [13:0] VEC [6] = '{
    {3'd0, 2'd0, 9'd200},
    {3'd5, 2'd3, 9'd400},
    {3'd7, 2'd2, 9'h1FF},
    {3'd2, 2'd1, 9'd0},
    {3'd4, 2'd0, 9'h155},
    {3'd3, 2'd2, 9'h0AA}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    waitc(1);
    sclk = 1'b1;
    waitc(3);
    sclk = 1'b0;
    waitc(3);
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_sload;
    sload = 1'b1;
    waitc(4);
    sload = 1'b0;
    waitc(5);
  endtask

  function automatic logic [31:0] cfg();
    return {18'd0, t_sel, n_code, m_val};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [13:0] w, other;
    waitc(3);
    // R10 reset state
    chk("R10 t_sel", t_sel, 0);
    chk("R10 m_val", m_val, 200);
    chk("R10 n_code", n_code, 1);
    chk("R10 sr_last", sr_last, 0);
    rst_n = 1'b1;
    waitc(6);
    // R2 / R4 vector walk
    for (int k = 0; k < 6; k++) begin
      shift_word(VEC[k]);
      pulse_sload();
      chk($sformatf("R2 vec%0d", k), cfg(), {18'd0, VEC[k]});
      shift_word(~VEC[k]);
      chk($sformatf("R4 hold vec%0d", k), cfg(), {18'd0, VEC[k]});
    end
    // R3 transparency and R11 passthrough of divider code
    w = {3'd6, 2'd3, 9'h123};
    sload = 1'b1;
    shift_word(w);
    waitc(5);
    chk("R3 follow word", cfg(), {18'd0, w});
    chk("R11 n_code passthrough", n_code, 3);
    shift_bit(1'b1);
    waitc(5);
    chk("R3 extra bit", cfg(), {18'd0, w[12:0], 1'b1});
    sload = 1'b0;
    waitc(5);
    other = {3'd5, 2'd2, 9'h0F0};
    shift_word(other);
    chk("R4 hold after R3", cfg(), {18'd0, w[12:0], 1'b1});
    // R9 / R1
    chk("R9 sr_last first bit", sr_last, other[13]);
    for (int i = 0; i < 10; i++) begin sdata = ~sdata; waitc(2); end
    chk("R1 no shift without sclk", sr_last, other[13]);
    shift_bit(1'b0);
    waitc(2);
    chk("R9 after one more bit", sr_last, other[12]);
    // sr now holds {other[12:0],0}
    w = {other[12:0], 1'b0};
    // R7 priority
    sload = 1'b1;
    pload = 1'b0;
    m_in = 9'd321; n_in = 2'b11;
    waitc(6);
    chk("R7 parallel wins m", m_val, 321);
    chk("R7 parallel wins n", n_code, 3);
    chk("R7 t forced", t_sel, 0);
    pload = 1'b1;
    waitc(6);
    chk("R7 serial after release", cfg(), {18'd0, w});
    sload = 1'b0;
    waitc(5);
    // R5 / R6 / R8
    pload = 1'b0;
    m_in = 9'd250; n_in = 2'b10;
    waitc(6);
    chk("R5 m follow", m_val, 250);
    chk("R8 t zero", t_sel, 0);
    m_in = 9'd399; n_in = 2'b00;
    waitc(6);
    chk("R5 m follow change", m_val, 399);
    chk("R5 n follow change", n_code, 0);
    pload = 1'b1;
    waitc(6);
    m_in = 9'd17; n_in = 2'b11;
    waitc(6);
    chk("R6 m held", m_val, 399);
    chk("R6 n held", n_code, 0);
    chk("R8 t stays zero", t_sel, 0);
    // R10 mid-run reset
    shift_word(14'h2001);
    chk("R9 msb set", sr_last, 1);
    rst_n = 1'b0;
    waitc(2);
    chk("R10 sr cleared", sr_last, 0);
    chk("R10 m from inputs", m_val, 17);
    chk("R10 n from inputs", n_code, 3);
    chk("R10 t zero", t_sel, 0);
    rst_n = 1'b1;
    waitc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule